// File: doc/BRIEF.md
# Control Word Majority Voter

This block guards a small control word that arrives once per frame against transmission errors. Each frame brings a control word and the verdict of a short block-code check made upstream: clean, corrected, or uncorrectable. Frames are grouped in runs of a parameterised length (16 by default). Within a group, every bit of the word is decided by majority over the frames that passed the code check. Frames judged uncorrectable still count toward the length of the group, but they cast no vote. When too few usable frames remain, the previous decision is kept.

The decided word feeds the muting and mode logic downstream. In the default 16-bit layout, that logic reads the audio-suppression flag and the non-audio flags from it. The word changes only when a group closes, and a one-cycle strobe marks each change. Losing frame lock throws away the partial group. Counting then restarts once lock is back.

The sequencer has three states:
- `ST_IDLE`: no lock. Strobes are ignored and the tallies are held clear.
- `ST_GATHER`: frames are counted and tallied.
- `ST_COMMIT`: one cycle in which the finished group is judged and loaded.

It has these transitions:
- IDLE→GATHER when lock is seen.
- GATHER→COMMIT on the strobe that completes the group.
- GATHER→IDLE and COMMIT→IDLE on loss of lock.
- COMMIT→GATHER otherwise.

Top module: `cvote_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `vote_word` is all zeros and `vote_upd` is 0. The sequencer starts in `ST_IDLE`.
- R2: A strobe is accepted only when `lock` is high at that clock edge and `lock` was also high at the previous edge. Strobes at any other time leave the word and the strobe output untouched.
- R3: For each bit, the output is 1 when twice the number of usable frames carrying a 1 exceeds the number of usable frames in the group. Otherwise it is 0, so a tie gives 0. Each bit is decided on its own.
- R4: `chk_status` codes are: 2'b00 clean, 2'b01 corrected, 2'b10 uncorrectable, 2'b11 uncorrectable. Only 00 and 01 frames vote. Every accepted strobe, usable or not, counts toward the group length.
- R5: When a group closes with fewer than `MIN_VALID` usable frames (9 by default), the whole word keeps its previous value and `vote_upd` stays low.
- R6: Suppose the accepted strobe that completes a group is sampled at edge k. Then `vote_word` takes its new value and `vote_upd` is high for exactly one cycle, both starting at edge k+1.
- R7: `vote_word` does not change in any cycle in which `vote_upd` is low.
- R8: Loss of lock at any edge discards the partial group and restarts the count. If lock is low at the edge that ends the commit cycle, the completed group is dropped with no update.
- R9: An accepted strobe that arrives in the commit cycle is the first frame of the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock | input | 1 | Frame lock indication, high while locked |
| frame_stb | input | 1 | One-cycle pulse marking a new frame's control word |
| ctrl_word | input | WORD_W | Control word of the current frame |
| chk_status | input | 2 | Block-code verdict for this frame (see R4) |
| vote_word | output | WORD_W | Post-majority control word |
| vote_upd | output | 1 | One-cycle pulse when `vote_word` is reloaded |

## Verification
Two functions can land in the same cycle, and both are provoked on purpose. The first is the commit of a finished group and the arrival of the first strobe of the next group: strobes are driven back to back, so the seventeenth falls in the commit cycle. That case is judged by whether the second group then closes after exactly fifteen further strobes. The second is the commit and a loss of lock: lock is dropped on the edge that ends the commit cycle. That case is judged by the word staying unchanged with no update pulse. A behavioural reference model built on a queue of usable words follows every clock, and its output is compared with the design's word and strobe in every cycle.

// File: rtl/cvote_pkg.sv
package cvote_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_COMMIT = 2'd2
    } vote_state_t;

    localparam logic [1:0] CHK_CLEAN = 2'b00;
    localparam logic [1:0] CHK_FIXED = 2'b01;
    localparam logic [1:0] CHK_FAIL  = 2'b10;

    // A frame may vote only when its block-code check did not give up.
    function automatic logic frame_usable(input logic [1:0] status);
        return (status == CHK_CLEAN) || (status == CHK_FIXED);
    endfunction

endpackage

// File: rtl/cvote_grpcnt.sv
module cvote_grpcnt #(
    parameter int GROUP_LEN = 16,
    parameter int CNT_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_LEN - 1);

    logic [CNT_W-1:0] cnt;

    // A clearing cycle never closes a group; a strobe in it opens the next one.
    assign last = step && !clear && (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= step ? CNT_W'(1) : '0;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cvote_tally.sv
module cvote_tally #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      add,
    input  logic [WORD_W-1:0]         word,
    output logic [WORD_W*CNT_W-1:0]   ones_flat,
    output logic [CNT_W-1:0]          valid_cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_cnt <= '0;
        end else if (clear) begin
            valid_cnt <= {{(CNT_W-1){1'b0}}, add};
        end else if (add) begin
            valid_cnt <= valid_cnt + CNT_W'(1);
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic [CNT_W-1:0] ones;
        logic             hit;

        assign hit = add & word[b];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ones <= '0;
            end else if (clear) begin
                ones <= {{(CNT_W-1){1'b0}}, hit};
            end else if (hit) begin
                ones <= ones + CNT_W'(1);
            end
        end

        assign ones_flat[b*CNT_W +: CNT_W] = ones;
    end

endmodule

// File: rtl/cvote_judge.sv
module cvote_judge #(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 5,
    parameter int MIN_VALID = 9
) (
    input  logic [WORD_W*CNT_W-1:0] ones_flat,
    input  logic [CNT_W-1:0]        valid_cnt,
    output logic [WORD_W-1:0]       decided,
    output logic                    enough
);
    localparam logic [CNT_W:0] QUORUM = (CNT_W+1)'(MIN_VALID);

    assign enough = {1'b0, valid_cnt} >= QUORUM;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic [CNT_W:0] twice;
        assign twice      = {ones_flat[b*CNT_W +: CNT_W], 1'b0};
        // Strictly more than half: a tie leaves the bit at 0.
        assign decided[b] = twice > {1'b0, valid_cnt};
    end

endmodule

// File: rtl/cvote_top.sv
module cvote_top
    import cvote_pkg::*;
#(
    parameter int                 WORD_W     = 16,
    parameter int                 GROUP_LEN  = 16,
    parameter int                 MIN_VALID  = GROUP_LEN / 2 + 1,
    parameter logic [WORD_W-1:0]  RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              frame_stb,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [1:0]        chk_status,
    output logic [WORD_W-1:0] vote_word,
    output logic              vote_upd
);
    localparam int CNT_W = $clog2(GROUP_LEN + 1);

    vote_state_t              state;
    vote_state_t              nxt;
    logic                     accept;
    logic                     usable;
    logic                     restart;
    logic                     group_last;
    logic                     enough;
    logic                     commit_ok;
    logic [WORD_W*CNT_W-1:0]  ones_flat;
    logic [CNT_W-1:0]         valid_cnt;
    logic [WORD_W-1:0]        decided;

    assign accept    = lock && frame_stb && (state != ST_IDLE);
    assign usable    = accept && frame_usable(chk_status);
    assign restart   = !lock || (state == ST_IDLE) || (state == ST_COMMIT);
    assign commit_ok = (state == ST_COMMIT) && lock && enough;

    cvote_grpcnt #(
        .GROUP_LEN (GROUP_LEN),
        .CNT_W     (CNT_W)
    ) grpcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .step  (accept),
        .last  (group_last)
    );

    cvote_tally #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) tally_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .add       (usable),
        .word      (ctrl_word),
        .ones_flat (ones_flat),
        .valid_cnt (valid_cnt)
    );

    cvote_judge #(
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W),
        .MIN_VALID (MIN_VALID)
    ) judge_i (
        .ones_flat (ones_flat),
        .valid_cnt (valid_cnt),
        .decided   (decided),
        .enough    (enough)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = lock ? ST_GATHER : ST_IDLE;
            ST_GATHER: begin
                if (!lock)           nxt = ST_IDLE;
                else if (group_last) nxt = ST_COMMIT;
                else                 nxt = ST_GATHER;
            end
            ST_COMMIT: nxt = lock ? ST_GATHER : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vote_word <= RESET_WORD;
            vote_upd  <= 1'b0;
        end else begin
            vote_upd <= commit_ok;
            if (commit_ok) vote_word <= decided;
        end
    end

endmodule

// File: rtl/cvote_chk.sv
module cvote_chk
    import cvote_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 5,
    parameter int MIN_VALID = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic              frame_stb,
    input logic [WORD_W-1:0] vote_word,
    input logic              vote_upd,
    input vote_state_t       state_q,
    input logic [CNT_W-1:0]  valid_cnt
);
    localparam logic [CNT_W:0] QUORUM = (CNT_W+1)'(MIN_VALID);

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_upd |-> $stable(vote_word));

    // R6
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_upd |=> !vote_upd);

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> !vote_upd);

    // R5
    quorum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_upd |-> ({1'b0, $past(valid_cnt)} >= QUORUM));

    // R2
    commit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> ($past(frame_stb) && $past(lock)));

endmodule

bind cvote_top cvote_chk #(
    .WORD_W    (WORD_W),
    .CNT_W     (CNT_W),
    .MIN_VALID (MIN_VALID)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (lock),
    .frame_stb (frame_stb),
    .vote_word (vote_word),
    .vote_upd  (vote_upd),
    .state_q   (state),
    .valid_cnt (valid_cnt)
);

// File: tb/cvote_top_tb_top.sv
module cvote_top_tb_top;
    localparam int W    = 16;
    localparam int G    = 16;
    localparam int MINV = 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         lock;
    logic         frame_stb;
    logic [W-1:0] ctrl_word;
    logic [1:0]   chk_status;
    logic [W-1:0] vote_word;
    logic         vote_upd;

    always #4 clk = ~clk;

    cvote_top #(.WORD_W(W), .GROUP_LEN(G)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock       (lock),
        .frame_stb  (frame_stb),
        .ctrl_word  (ctrl_word),
        .chk_status (chk_status),
        .vote_word  (vote_word),
        .vote_upd   (vote_upd)
    );

    int  checks   = 0;
    int  errors   = 0;
    int  upd_seen = 0;
    bit  done     = 0;

    // Behavioural reference model
    logic [W-1:0] m_word;
    bit           m_upd;
    bit           m_armed;
    bit           m_pend;
    bit           m_new;
    int           m_nfrm;
    logic [W-1:0] m_q[$];

    function automatic logic [W-1:0] model_vote();
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            int ones = 0;
            foreach (m_q[i]) if (m_q[i][b]) ones++;
            r[b] = (2 * ones > m_q.size());
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_upd = 0; m_armed = 0; m_pend = 0; m_nfrm = 0;
            m_q.delete();
        end else begin
            m_new = 0;
            if (m_pend) begin
                m_pend = 0;
                if (lock && m_q.size() >= MINV) begin
                    m_word = model_vote();
                    m_new  = 1;
                end
                m_q.delete();
                m_nfrm = 0;
            end
            if (!lock) begin
                m_q.delete(); m_nfrm = 0; m_pend = 0;
            end else if (frame_stb && m_armed) begin
                m_nfrm++;
                if (chk_status == 2'b00 || chk_status == 2'b01) m_q.push_back(ctrl_word);
                if (m_nfrm == G) m_pend = 1;
            end
            m_armed = lock;
            m_upd   = m_new;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (vote_word !== m_word || vote_upd !== m_upd) begin
                errors++;
                $display("FAIL R6 R7 per-cycle: word=%h upd=%0b expected word=%h upd=%0b",
                         vote_word, vote_upd, m_word, m_upd);
            end
            if (vote_upd) upd_seen++;
        end
    end

    task automatic check_val(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic frame(input logic [W-1:0] w, input logic [1:0] s, input int gap);
        frame_stb  = 1'b1;
        ctrl_word  = w;
        chk_status = s;
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; lock = 0; frame_stb = 0; ctrl_word = '0; chk_status = 2'b00;
        repeat (3) @(negedge clk);
        check_val("R1 reset word", vote_word, 16'h0000);
        check_val("R1 reset upd", {15'd0, vote_upd}, 16'h0000);
        rst_n = 1;
        @(negedge clk);
        check_val("R1 word after release", vote_word, 16'h0000);

        // R2: strobes without lock
        for (int i = 0; i < G; i++) frame(16'hFFFF, 2'b00, 1);
        repeat (3) @(negedge clk);
        check_val("R2 unlocked word", vote_word, 16'h0000);
        check_val("R2 unlocked updates", 16'(upd_seen), 16'd0);

        lock = 1;
        @(negedge clk);

        // R3: unanimous group
        for (int i = 0; i < G; i++) frame(16'hA5C3, 2'b00, 2);
        repeat (2) @(negedge clk);
        check_val("R3 unanimous", vote_word, 16'hA5C3);
        check_val("R6 one pulse", 16'(upd_seen), 16'd1);

        // R4: uncorrectable frames excluded
        for (int i = 0; i < 5; i++) frame(16'h3C3C, (i % 2 == 0) ? 2'b00 : 2'b01, 1);
        for (int i = 0; i < 4; i++) frame(16'h0000, 2'b00, 1);
        for (int i = 0; i < 7; i++) frame(16'h0000, (i == 3) ? 2'b11 : 2'b10, 1);
        repeat (3) @(negedge clk);
        check_val("R4 exclusion", vote_word, 16'h3C3C);

        // R3: tie gives 0
        for (int i = 0; i < 5; i++) frame(16'hFFFF, 2'b00, 1);
        for (int i = 0; i < 5; i++) frame(16'h0000, 2'b01, 1);
        for (int i = 0; i < 6; i++) frame(16'hFFFF, 2'b10, 1);
        repeat (3) @(negedge clk);
        check_val("R3 tie", vote_word, 16'h0000);
        check_val("R3 tie updates", 16'(upd_seen), 16'd3);

        // R5: below quorum, hold
        for (int i = 0; i < 8; i++) frame(16'hFFFF, 2'b00, 1);
        for (int i = 0; i < 8; i++) frame(16'hFFFF, 2'b10, 1);
        repeat (3) @(negedge clk);
        check_val("R5 held word", vote_word, 16'h0000);
        check_val("R5 no update", 16'(upd_seen), 16'd3);

        // R8: lock loss mid-group
        for (int i = 0; i < 10; i++) frame(16'hAAAA, 2'b00, 1);
        lock = 0;
        repeat (2) @(negedge clk);
        lock = 1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) frame(16'h5555, 2'b00, 1);
        repeat (3) @(negedge clk);
        check_val("R8 partial discarded", 16'(upd_seen), 16'd3);
        for (int i = 0; i < 10; i++) frame(16'h5555, 2'b00, 1);
        repeat (3) @(negedge clk);
        check_val("R8 relock group", vote_word, 16'h5555);

        // R9: strobe in the commit cycle opens the next group
        for (int i = 0; i < G; i++) frame(16'h1111, 2'b00, 0);
        for (int i = 0; i < G; i++) frame(16'h2222, 2'b00, (i == G - 1) ? 3 : 0);
        check_val("R9 back-to-back updates", 16'(upd_seen), 16'd6);
        check_val("R9 second group", vote_word, 16'h2222);

        // R8: lock lost at the end of the commit cycle
        for (int i = 0; i < G; i++) frame(16'h7777, 2'b00, 0);
        lock = 0;
        repeat (3) @(negedge clk);
        check_val("R8 commit dropped word", vote_word, 16'h2222);
        check_val("R8 commit dropped upd", 16'(upd_seen), 16'd6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule